// File: doc/BRIEF.md
# Sub-word Load/Store Lane Aligner

This block sits between a 32-bit register and a 32-bit external data bus and handles aligned byte, halfword and word transfers. On the read side it picks the addressed byte or byte pair out of the bus word and moves it down to bit 0 of the result. It then fills the bits above with zeros or with copies of the loaded value's top bit, as the signed flag selects.

On the write side it copies the source byte or halfword into every lane of the outgoing bus word. It also drives one write enable per byte lane, so that memory commits only the addressed lanes.

The byte offset, the access size and a big/little-endian mode input decide lane selection at run time. An access that breaks natural alignment raises a flag and suppresses every write enable. The block is purely combinational, so all outputs follow the inputs in the same cycle.

Top module: `lane_aligner`

## Requirements
- R1: With `size` = 2'b10 or 2'b11 (word), `load_val` equals `bus_rd` and `bus_wr` equals `wr_src`, unchanged in both endian modes.
- R2: With `size` = 2'b00 (byte), `load_val[7:0]` is byte lane L of `bus_rd` (bits 8L+7..8L). L equals `addr_lo` when `big_end` = 0 and 3 − `addr_lo` when `big_end` = 1.
- R3: With `size` = 2'b01 (halfword), `load_val[15:0]` is `bus_rd[31:16]` when `addr_lo[1]` XOR `big_end` is 1, and `bus_rd[15:0]` otherwise.
- R4: For a byte or halfword load with `sign_ext` = 0, every bit of `load_val` above the loaded value is 0.
- R5: For a byte or halfword load with `sign_ext` = 1, every bit of `load_val` above the loaded value equals the loaded value's top bit (bit 7 for a byte, bit 15 for a halfword).
- R6: For a byte store, `bus_wr` is `wr_src[7:0]` repeated in all four lanes. For a halfword store, `bus_wr` is `wr_src[15:0]` repeated in both halves. `sign_ext` has no effect on `bus_wr`.
- R7: With `wr` = 1 and no misalignment, `lane_we` bit i enables bus bits 8i+7..8i. The value is 4'b1111 for a word. For a halfword it is 4'b1100 when `addr_lo[1]` XOR `big_end` is 1 and 4'b0011 otherwise. For a byte it is 1 shifted left by L, with L as in R2.
- R8: `misalign` is 1 for a halfword with `addr_lo[0]` = 1 or a word with `addr_lo` ≠ 0, and 0 otherwise. While it is 1, `lane_we` is 4'b0000.
- R9: With `wr` = 0, `lane_we` is 4'b0000 for every address, size and mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bus_rd | input | 32 | Word read from the external data bus |
| addr_lo | input | 2 | Low two bits of the access address |
| size | input | 2 | Access size: 00 byte, 01 halfword, 1x word |
| sign_ext | input | 1 | 1 selects sign fill for sub-word loads, 0 selects zero fill |
| big_end | input | 1 | Endian mode: 0 little endian, 1 big endian |
| wr | input | 1 | Store access; enables the lane write enables |
| wr_src | input | 32 | Register value to be stored |
| load_val | output | 32 | Aligned and extended load result |
| bus_wr | output | 32 | Lane-replicated store data for the bus |
| lane_we | output | 4 | Per-byte-lane write enables, bit i for bits 8i+7..8i |
| misalign | output | 1 | Access violates natural alignment for its size |

## Verification
All outputs are combinational, so each result is due in the same cycle its inputs are applied, with no register in the path. The bench therefore changes inputs just after a rising edge and reads every output at the following falling edge, half a period later. It sweeps every combination of offset, size code, sign flag, endian mode and write flag over several bus and source words. The words are chosen so that both sign polarities appear in each lane.

// File: rtl/lane_aligner.sv
module lane_aligner (
  input  logic [31:0] bus_rd,
  input  logic [1:0]  addr_lo,
  input  logic [1:0]  size,
  input  logic        sign_ext,
  input  logic        big_end,
  input  logic        wr,
  input  logic [31:0] wr_src,
  output logic [31:0] load_val,
  output logic [31:0] bus_wr,
  output logic [3:0]  lane_we,
  output logic        misalign
);
  localparam int LANE_W = 8;

  logic        is_byte, is_half, is_word;
  logic [1:0]  lane;
  logic        hi_half;
  logic [7:0]  b_val;
  logic [15:0] h_val;
  logic [3:0]  mask;

  assign is_byte = (size == 2'b00);
  assign is_half = (size == 2'b01);
  assign is_word = size[1];

  assign lane    = addr_lo ^ {2{big_end}};
  assign hi_half = addr_lo[1] ^ big_end;

  assign b_val = bus_rd[LANE_W*lane +: LANE_W];
  assign h_val = hi_half ? bus_rd[31:16] : bus_rd[15:0];

  always_comb begin
    if (is_word)
      load_val = bus_rd;
    else if (is_half)
      load_val = {{16{sign_ext & h_val[15]}}, h_val};
    else
      load_val = {{24{sign_ext & b_val[7]}}, b_val};
  end

  always_comb begin
    if (is_word)      bus_wr = wr_src;
    else if (is_half) bus_wr = {2{wr_src[15:0]}};
    else              bus_wr = {4{wr_src[7:0]}};
  end

  always_comb begin
    if (is_word)      mask = 4'b1111;
    else if (is_half) mask = hi_half ? 4'b1100 : 4'b0011;
    else              mask = 4'b0001 << lane;
  end

  assign misalign = (is_half & addr_lo[0]) | (is_word & (|addr_lo));
  assign lane_we  = (wr && !misalign) ? mask : 4'b0000;

  logic unused_ok;
  assign unused_ok = is_byte;
endmodule

module lane_aligner_chk (
  input logic [31:0] bus_rd,
  input logic [1:0]  addr_lo,
  input logic [1:0]  size,
  input logic        sign_ext,
  input logic        wr,
  input logic [31:0] wr_src,
  input logic [31:0] load_val,
  input logic [31:0] bus_wr,
  input logic [3:0]  lane_we,
  input logic        misalign
);
  always_comb begin
    if (size[1]) p_word_pass_r1: assert (load_val == bus_rd && bus_wr == wr_src);
    if (size == 2'b00 && !sign_ext) p_byte_zero_r4: assert (load_val[31:8] == 24'h0);
    if (size == 2'b01 && sign_ext)
      p_half_sign_r5: assert (load_val[31:16] == {16{load_val[15]}});
    if (size == 2'b00) p_byte_rep_r6: assert (bus_wr == {4{wr_src[7:0]}});
    if (wr && !misalign)
      p_we_count_r7: assert ($countones(lane_we) == (size[1] ? 4 : (size[0] ? 2 : 1)));
    if (misalign) p_misalign_quiet_r8: assert (lane_we == 4'b0000);
    if (!wr) p_idle_quiet_r9: assert (lane_we == 4'b0000);
  end
endmodule

bind lane_aligner lane_aligner_chk i_chk (
  .bus_rd(bus_rd), .addr_lo(addr_lo), .size(size), .sign_ext(sign_ext),
  .wr(wr), .wr_src(wr_src), .load_val(load_val), .bus_wr(bus_wr),
  .lane_we(lane_we), .misalign(misalign)
);

// File: tb/test_lane_aligner.sv
module test_lane_aligner;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [31:0] bus_rd, wr_src, load_val, bus_wr;
  logic [1:0]  addr_lo, size;
  logic        sign_ext, big_end, wr, misalign;
  logic [3:0]  lane_we;

  lane_aligner i_lane_aligner (
    .bus_rd(bus_rd), .addr_lo(addr_lo), .size(size), .sign_ext(sign_ext),
    .big_end(big_end), .wr(wr), .wr_src(wr_src), .load_val(load_val),
    .bus_wr(bus_wr), .lane_we(lane_we), .misalign(misalign)
  );

  int checks = 0;
  int errors = 0;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h (addr=%0d size=%0d s=%0b be=%0b wr=%0b)",
               req, act, exp, addr_lo, size, sign_ext, big_end, wr);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD*200000);
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [31:0] pats_rd [3];
    logic [31:0] pats_src [3];
    pats_rd[0] = 32'h8F7E_01C3; pats_rd[1] = 32'h3C81_F27A; pats_rd[2] = 32'hFFFF_0000;
    pats_src[0] = 32'hA5C3_1E96; pats_src[1] = 32'h1234_5678; pats_src[2] = 32'h00FF_807F;
    bus_rd = '0; wr_src = '0; addr_lo = '0; size = '0; sign_ext = 0; big_end = 0; wr = 0;
    repeat (2) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R9 idle state we", {28'h0, lane_we}, 32'h0);
    chk("R8 idle state misalign", {31'h0, misalign}, 32'h0);
    for (int p = 0; p < 3; p++)
      for (int a = 0; a < 4; a++)
        for (int sz = 0; sz < 4; sz++)
          for (int s = 0; s < 2; s++)
            for (int be = 0; be < 2; be++)
              for (int w = 0; w < 2; w++) begin
                logic [31:0] e_ld, e_wr;
                logic [3:0]  e_we;
                logic        e_mis, upper;
                int          l;
                @(posedge clk);
                bus_rd = pats_rd[p]; wr_src = pats_src[p];
                addr_lo = 2'(a); size = 2'(sz); sign_ext = s[0]; big_end = be[0]; wr = w[0];
                l = (be != 0) ? 3 - a : a;
                upper = ((a >= 2) != (be != 0));
                if (sz >= 2) begin
                  e_ld = pats_rd[p]; e_wr = pats_src[p]; e_we = 4'hF; e_mis = (a != 0);
                end else if (sz == 1) begin
                  e_ld = upper ? (pats_rd[p] >> 16) : (pats_rd[p] & 32'hFFFF);
                  if (s != 0 && e_ld >= 32'h8000) e_ld = e_ld | 32'hFFFF_0000;
                  e_wr = (pats_src[p] & 32'hFFFF) * 32'h0001_0001;
                  e_we = upper ? 4'hC : 4'h3; e_mis = (a % 2 == 1);
                end else begin
                  e_ld = (pats_rd[p] >> (8*l)) & 32'hFF;
                  if (s != 0 && e_ld >= 32'h80) e_ld = e_ld | 32'hFFFF_FF00;
                  e_wr = (pats_src[p] & 32'hFF) * 32'h0101_0101;
                  e_we = 4'(1 << l); e_mis = 1'b0;
                end
                if (w == 0 || e_mis) e_we = 4'h0;
                @(negedge clk);
                if (sz >= 2) begin
                  chk("R1 word load", load_val, e_ld);
                  chk("R1 word store", bus_wr, e_wr);
                end else begin
                  chk(sz == 1 ? "R3 half lane" : "R2 byte lane",
                      load_val & (sz == 1 ? 32'hFFFF : 32'hFF),
                      e_ld & (sz == 1 ? 32'hFFFF : 32'hFF));
                  chk(s != 0 ? "R5 sign fill" : "R4 zero fill", load_val, e_ld);
                  chk("R6 store replicate", bus_wr, e_wr);
                end
                chk(w == 0 ? "R9 no write" : (e_mis ? "R8 misaligned we" : "R7 lane we"),
                    {28'h0, lane_we}, {28'h0, e_we});
                chk("R8 misalign flag", {31'h0, misalign}, {31'h0, e_mis});
              end
    finish_run();
  end
endmodule